// File: doc/BRIEF.md
# Data-Processing Second-Operand Generator

This block forms the second operand of a data-processing instruction, together with the carry-out of the shifter. It is purely combinational. It takes the 32-bit instruction word, the values already read for the shifted register and the shift-amount register, and the current carry flag. It returns the operand and the carry that the ALU and the flag logic downstream will use. It does not read the register file, evaluate conditions, compute results or write flags.

The instruction word selects one of three forms. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit amount held in the instruction. The third is a register shifted by the low byte of a second register. Shift amounts of zero, exactly the word width and more than the word width each give their own operand and carry. In the immediate-amount form, a zero amount means something different for each shift kind.

The block has no storage and no handshake. It sits between the operand read and the ALU, and its outputs are valid in the same cycle as its inputs.

Top module: `dp_operand2_gen`

## Requirements
- R1: When instruction bit 25 is 1, the operand is bits 7:0 zero-extended and rotated right by twice the value of bits 11:8.
- R2: In the rotated-constant form, the carry-out equals carry_i when bits 11:8 are zero. Otherwise it equals bit 31 of the operand.
- R3: When bit 25 is 0 and bit 4 is 0, bits 6:5 = 00 select a left shift by bits 11:7. An amount of 0 returns rm_i unchanged with carry carry_i. A non-zero amount n gives the truncated left shift with carry rm_i[32-n].
- R4: In the immediate-amount form, an amount of 0 with bits 6:5 = 01 (logical right) or 10 (arithmetic right) acts as a shift by 32. Logical right gives operand 0. Arithmetic right fills every bit with rm_i[31]. Both carry out rm_i[31].
- R5: In the immediate-amount form, bits 6:5 = 11 (rotate right) with amount 0 gives a 33-bit rotate through carry. The operand is {carry_i, rm_i[31:1]} and the carry is rm_i[0].
- R6: In the immediate-amount form, a non-zero amount n with a logical right, arithmetic right or rotate right shift gives the shifted rm_i with carry rm_i[n-1].
- R7: When bit 25 is 0 and bit 4 is 1, the amount is rs_i[7:0] only, and rs_i[31:8] has no effect. An amount of 0 returns rm_i unchanged with carry carry_i.
- R8: For a register amount, a left or logical right shift by 32 gives operand 0. The carry is rm_i[0] for a left shift and rm_i[31] for a logical right shift. Any amount above 32 gives operand 0 and carry 0.
- R9: For a register amount, an arithmetic right shift by 32 or more fills every operand bit with rm_i[31] and carries out rm_i[31].
- R10: For a register amount, a rotate right with rs_i[7:0] non-zero and rs_i[4:0] zero returns rm_i with carry rm_i[31]. Otherwise it rotates by rs_i[4:0] with carry rm_i[rs_i[4:0]-1].
- R11: A register amount from 1 to 31 shifts left, logical right or arithmetic right as usual. The carry is the last bit shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word; bits 25, 11:0 are decoded |
| rm_i | input | 32 | Value of the register to be shifted |
| rs_i | input | 32 | Value of the register holding the shift amount |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second operand for the ALU |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench covers every rotate constant and every rotate field with both carry values. It also covers every immediate shift amount for each shift kind, and register amounts from 0 to 40 plus several larger bytes, both with and without junk in the upper bits of rs_i. A design that handled only amounts 1 to 31 would go wrong in several ways. It would pass rm_i through for immediate logical or arithmetic shifts by 0 instead of clearing or sign-filling. It would leave bits behind on register shifts of 32 and above. It would take the left-shift carry from the wrong end.

Other corner cases are also covered. A zero rotate amount treated as a plain rotate would drop the carry flag from bit 31. A design that read more than the low byte of rs_i would shift by a wrong amount when the upper bits are set. Register rotates by multiples of 32 catch a carry still taken from carry_i.

// File: rtl/op2_pkg.sv
package op2_pkg;
  localparam int WORD_W = 32;

  // Instruction field positions the decoder depends on
  localparam int POS_CONST_FORM = 25;
  localparam int POS_REG_AMT    = 4;
  localparam int POS_KIND_LO    = 5;
  localparam int POS_IMM_AMT_LO = 7;
  localparam int POS_ROT_LO     = 8;
  localparam int CONST_W        = 8;
  localparam int ROT_W          = 4;
  localparam int REG_AMT_W      = 8;

  typedef enum logic [1:0] {
    SK_LEFT  = 2'b00,
    SK_RIGHT = 2'b01,
    SK_ARITH = 2'b10,
    SK_ROT   = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/op2_rotator.sv
module op2_rotator #(
  parameter int DATA_W = op2_pkg::WORD_W,
  localparam int LOG_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [LOG_W-1:0]  amt_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] stage [0:LOG_W];

  assign stage[0] = din_i;

  // Log-depth right rotator: stage s rotates by 2**s when amt_i[s] is set
  for (genvar s = 0; s < LOG_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][STEP-1:0], stage[s][DATA_W-1:STEP]}
                                 : stage[s];
  end

  assign dout_o = stage[LOG_W];
endmodule

// File: rtl/op2_imm_rotate.sv
module op2_imm_rotate #(
  parameter int DATA_W  = op2_pkg::WORD_W,
  parameter int CONST_W = op2_pkg::CONST_W,
  parameter int ROT_W   = op2_pkg::ROT_W,
  localparam int LOG_W  = $clog2(DATA_W)
) (
  input  logic [CONST_W-1:0] const_i,
  input  logic [ROT_W-1:0]   rot_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  value_o,
  output logic               carry_o
);
  logic [LOG_W-1:0]  rot_amt;
  logic [DATA_W-1:0] widened;

  assign widened = DATA_W'(const_i);
  assign rot_amt = LOG_W'({rot_i, 1'b0});

  op2_rotator #(.DATA_W(DATA_W)) u_rot (
    .din_i (widened),
    .amt_i (rot_amt),
    .dout_o(value_o)
  );

  assign carry_o = (rot_i == '0) ? carry_i : value_o[DATA_W-1];
endmodule

// File: rtl/op2_amount_decode.sv
module op2_amount_decode #(
  parameter int DATA_W    = op2_pkg::WORD_W,
  parameter int REG_AMT_W = op2_pkg::REG_AMT_W,
  localparam int LOG_W    = $clog2(DATA_W)
) (
  input  logic                  reg_amt_i,
  input  op2_pkg::shift_kind_e  kind_i,
  input  logic [LOG_W-1:0]      imm_amt_i,
  input  logic [REG_AMT_W-1:0]  reg_amt_val_i,
  output logic [REG_AMT_W-1:0]  amt_o,
  output logic                  rrx_o
);
  localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(DATA_W);

  always_comb begin
    rrx_o = 1'b0;
    amt_o = REG_AMT_W'(imm_amt_i);
    if (reg_amt_i) begin
      amt_o = reg_amt_val_i;
    end else if (imm_amt_i == '0) begin
      unique case (kind_i)
        op2_pkg::SK_RIGHT,
        op2_pkg::SK_ARITH: amt_o = FULL;
        op2_pkg::SK_ROT:   rrx_o = 1'b1;
        default:           amt_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/op2_shift_path.sv
module op2_shift_path #(
  parameter int DATA_W    = op2_pkg::WORD_W,
  parameter int REG_AMT_W = op2_pkg::REG_AMT_W,
  localparam int LOG_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]    value_i,
  input  op2_pkg::shift_kind_e kind_i,
  input  logic [REG_AMT_W-1:0] amt_i,
  input  logic                 rrx_i,
  input  logic                 carry_i,
  output logic [DATA_W-1:0]    value_o,
  output logic                 carry_o
);
  localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(DATA_W);
  localparam logic [DATA_W-1:0]    ONES = '1;

  logic [LOG_W-1:0]  lo, lo_neg, lo_m1;
  logic [DATA_W-1:0] rot_r, rot_l, mask_r, mask_l, fill;
  logic              amt_zero, amt_full, amt_past;

  assign lo       = amt_i[LOG_W-1:0];
  assign lo_neg   = LOG_W'(0) - lo;
  assign lo_m1    = lo - LOG_W'(1);
  assign amt_zero = (amt_i == '0);
  assign amt_full = (amt_i == FULL);
  assign amt_past = (amt_i > FULL);
  assign mask_r   = ONES >> lo;
  assign mask_l   = ONES << lo;
  assign fill     = {DATA_W{value_i[DATA_W-1]}};

  // Right rotation by lo; left shift reuses a right rotation by -lo
  op2_rotator #(.DATA_W(DATA_W)) u_rot_r (
    .din_i (value_i),
    .amt_i (lo),
    .dout_o(rot_r)
  );

  op2_rotator #(.DATA_W(DATA_W)) u_rot_l (
    .din_i (value_i),
    .amt_i (lo_neg),
    .dout_o(rot_l)
  );

  always_comb begin
    value_o = value_i;
    carry_o = carry_i;
    if (rrx_i) begin
      value_o = {carry_i, value_i[DATA_W-1:1]};
      carry_o = value_i[0];
    end else if (!amt_zero) begin
      unique case (kind_i)
        op2_pkg::SK_LEFT: begin
          if (amt_past) begin
            value_o = '0;
            carry_o = 1'b0;
          end else if (amt_full) begin
            value_o = '0;
            carry_o = value_i[0];
          end else begin
            value_o = rot_l & mask_l;
            carry_o = value_i[lo_neg];
          end
        end
        op2_pkg::SK_RIGHT: begin
          if (amt_past) begin
            value_o = '0;
            carry_o = 1'b0;
          end else if (amt_full) begin
            value_o = '0;
            carry_o = value_i[DATA_W-1];
          end else begin
            value_o = rot_r & mask_r;
            carry_o = value_i[lo_m1];
          end
        end
        op2_pkg::SK_ARITH: begin
          if (amt_past || amt_full) begin
            value_o = fill;
            carry_o = value_i[DATA_W-1];
          end else begin
            value_o = (rot_r & mask_r) | (fill & ~mask_r);
            carry_o = value_i[lo_m1];
          end
        end
        default: begin
          if (lo == '0) begin
            value_o = value_i;
            carry_o = value_i[DATA_W-1];
          end else begin
            value_o = rot_r;
            carry_o = value_i[lo_m1];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dp_operand2_gen.sv
module dp_operand2_gen #(
  parameter int DATA_W = op2_pkg::WORD_W
) (
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o
);
  import op2_pkg::*;

  localparam int LOG_W = $clog2(DATA_W);

  logic                 const_form, reg_amt;
  shift_kind_e          kind;
  logic [CONST_W-1:0]   const_val;
  logic [ROT_W-1:0]     rot_val;
  logic [LOG_W-1:0]     imm_amt;
  logic [REG_AMT_W-1:0] reg_amt_val, eff_amt;
  logic                 rrx;
  logic [DATA_W-1:0]    const_op, shift_op;
  logic                 const_c, shift_c;
  logic                 unused_bits;

  assign const_form  = instr_i[POS_CONST_FORM];
  assign reg_amt     = instr_i[POS_REG_AMT];
  assign kind        = shift_kind_e'(instr_i[POS_KIND_LO +: 2]);
  assign const_val   = instr_i[0 +: CONST_W];
  assign rot_val     = instr_i[POS_ROT_LO +: ROT_W];
  assign imm_amt     = instr_i[POS_IMM_AMT_LO +: LOG_W];
  assign reg_amt_val = rs_i[REG_AMT_W-1:0];
  assign unused_bits = ^{instr_i[31:26], instr_i[24:12], rs_i[DATA_W-1:REG_AMT_W]};

  op2_imm_rotate #(.DATA_W(DATA_W)) u_const (
    .const_i(const_val),
    .rot_i  (rot_val),
    .carry_i(carry_i),
    .value_o(const_op),
    .carry_o(const_c)
  );

  op2_amount_decode #(.DATA_W(DATA_W)) u_amt (
    .reg_amt_i    (reg_amt),
    .kind_i       (kind),
    .imm_amt_i    (imm_amt),
    .reg_amt_val_i(reg_amt_val),
    .amt_o        (eff_amt),
    .rrx_o        (rrx)
  );

  op2_shift_path #(.DATA_W(DATA_W)) u_shift (
    .value_i(rm_i),
    .kind_i (kind),
    .amt_i  (eff_amt),
    .rrx_i  (rrx),
    .carry_i(carry_i),
    .value_o(shift_op),
    .carry_o(shift_c)
  );

  assign operand_o = const_form ? const_op : shift_op;
  assign carry_o   = const_form ? const_c  : shift_c;

  always_comb begin
    if (const_form) begin
      p_const_bits_kept_r1: assert ($countones(operand_o) == $countones(const_val))
        else $error("constant rotate changed bit count");
      if (rot_val != '0) begin
        p_const_carry_top_r2: assert (carry_o == operand_o[DATA_W-1])
          else $error("constant carry not taken from top bit");
      end
    end else begin
      if (reg_amt && reg_amt_val == '0) begin
        p_reg_zero_pass_r7: assert (operand_o == rm_i && carry_o == carry_i)
          else $error("zero register amount altered operand");
      end
      if (reg_amt && (kind == SK_LEFT || kind == SK_RIGHT) &&
          reg_amt_val > REG_AMT_W'(DATA_W)) begin
        p_far_clear_r8: assert (operand_o == '0 && !carry_o)
          else $error("oversized shift left residue");
      end
      if (kind == SK_ARITH) begin
        p_arith_sign_r9: assert (operand_o[DATA_W-1] == rm_i[DATA_W-1])
          else $error("arithmetic shift lost sign");
      end
      if (!reg_amt && kind == SK_ROT && imm_amt == '0) begin
        p_rrx_r5: assert (operand_o[DATA_W-1] == carry_i && carry_o == rm_i[0])
          else $error("rotate through carry wrong");
      end
      if (kind == SK_ROT && !(!reg_amt && imm_amt == '0)) begin
        p_rot_bits_kept_r10: assert ($countones(operand_o) == $countones(rm_i))
          else $error("rotate changed bit count");
      end
    end
  end
endmodule

// File: tb/tb_dp_operand2_gen.sv
module tb_dp_operand2_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] rm = '0;
  logic [31:0] rs = '0;
  logic        cin = 1'b0;
  logic [31:0] op;
  logic        cout;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_operand2_gen dut (
    .instr_i  (instr),
    .rm_i     (rm),
    .rs_i     (rs),
    .carry_i  (cin),
    .operand_o(op),
    .carry_o  (cout)
  );

  always @(posedge clk) begin
    if (rst) cycles <= 0;
    else begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  // Arithmetic reference model: returns {carry, operand}
  function automatic logic [32:0] model(input logic [31:0] i, input logic [31:0] m,
                                        input logic [31:0] s, input logic c);
    logic [63:0] t;
    logic [31:0] v;
    int a;
    if (i[25]) begin
      t = {24'b0, i[7:0], 24'b0, i[7:0]} >> (2 * int'(i[11:8]));
      v = t[31:0];
      return {(i[11:8] == 0) ? c : v[31], v};
    end
    a = i[4] ? int'(s[7:0]) : int'(i[11:7]);
    if (!i[4] && a == 0) begin
      case (i[6:5])
        2'b01, 2'b10: a = 32;
        2'b11: return {m[0], c, m[31:1]};
        default: a = 0;
      endcase
    end
    if (a == 0) return {c, m};
    case (i[6:5])
      2'b00: begin
        if (a > 32) return 33'b0;
        t = {32'b0, m} << a;
        return {t[32], t[31:0]};
      end
      2'b01: begin
        if (a > 32) return 33'b0;
        t = {m, 32'b0} >> a;
        return {t[31], t[63:32]};
      end
      2'b10: begin
        t = 64'($signed({m, 32'b0}) >>> ((a > 32) ? 32 : a));
        return {t[31], t[63:32]};
      end
      default: begin
        if (a % 32 == 0) return {m[31], m};
        t = {m, m} >> (a % 32);
        return {t[31], t[31:0]};
      end
    endcase
  endfunction

  task automatic apply(input string tag, input logic [31:0] i, input logic [31:0] m,
                       input logic [31:0] s, input logic c);
    logic [32:0] exp;
    @(negedge clk);
    instr = i; rm = m; rs = s; cin = c;
    #1;
    exp = model(i, m, s, c);
    checks = checks + 1;
    if (op !== exp[31:0] || cout !== exp[32]) begin
      errors = errors + 1;
      $display("FAIL %s: instr=%h rm=%h rs=%h c=%b got op=%h c=%b expected op=%h c=%b",
               tag, i, m, s, c, op, cout, exp[31:0], exp[32]);
    end
  endtask

  logic [31:0] pats [0:5];
  int reg_amts [0:44];

  initial begin
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hDEAD_BEEF;
    pats[3] = 32'h1234_5678; pats[4] = 32'hFFFF_FFFF; pats[5] = 32'h0000_0000;
    for (int k = 0; k <= 40; k++) reg_amts[k] = k;
    reg_amts[41] = 64; reg_amts[42] = 128; reg_amts[43] = 200; reg_amts[44] = 255;

    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state: all-zero inputs give a zero operand and zero carry (R3)
    @(negedge clk); #1;
    checks = checks + 1;
    if (op !== 32'h0 || cout !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R3 idle: got op=%h c=%b expected op=00000000 c=0", op, cout);
    end

    // R1 / R2: every rotate field and constant, both carry values
    for (int k = 0; k < 4096; k++)
      for (int c = 0; c < 2; c++)
        apply((k[11:8] == 0) ? "R1/R2 zero-rot" : "R1/R2",
              32'hE2A5_0000 | 32'(k), 32'hCAFE_F00D, 32'h0000_0011, c[0]);

    // R3..R6: immediate amounts
    for (int kd = 0; kd < 4; kd++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++) begin
            string tag;
            if (kd == 0) tag = "R3";
            else if (a == 0 && kd == 3) tag = "R5";
            else if (a == 0) tag = "R4";
            else tag = "R6";
            apply(tag, 32'hE123_4000 | (32'(a) << 7) | (32'(kd) << 5) | 32'h3,
                  pats[p], 32'h0, c[0]);
          end

    // R7..R11: register amounts, with and without junk above the low byte
    for (int kd = 0; kd < 4; kd++)
      for (int j = 0; j < 45; j++)
        for (int p = 0; p < 6; p++)
          for (int c = 0; c < 2; c++)
            for (int g = 0; g < 2; g++) begin
              string tag;
              int a;
              a = reg_amts[j];
              if (g == 1) tag = "R7 upper";
              else if (a == 0) tag = "R7";
              else if (kd == 3) tag = "R10";
              else if (kd == 2 && a >= 32) tag = "R9";
              else if (a >= 32) tag = "R8";
              else tag = "R11";
              apply(tag, 32'hE000_0A10 | (32'(kd) << 5) | 32'h2, pats[p],
                    (g == 1 ? 32'hABCD_E100 : 32'h0) | 32'(a), c[0]);
            end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule